// File: doc/BRIEF.md
# External Interrupt Sense and Flag Unit

This unit watches three external interrupt pins on behalf of an interrupt controller. Each pin passes through a two-stage synchronizer and then a register that holds the previous sampled level. Comparing the two levels finds edges. Pins 0 and 1 each have a two-bit sense mode, which selects low level, any change, falling edge or rising edge. Pin 2 detects edges only, and a single polarity bit picks which edge. In an edge mode, a detected event latches a sticky flag. The flag stays set until the controller acknowledges that source or software writes a 1 to its flag bit. In low-level mode no flag is latched, and the request follows the synchronized pin.

Each channel's flag is a two-state machine. The states are `FLAG_IDLE` and `FLAG_PENDING`. The transition *latch* moves `FLAG_IDLE` to `FLAG_PENDING` when an edge-mode event is detected. The transition *release* moves `FLAG_PENDING` back to `FLAG_IDLE` when a clear (acknowledge or write-1) arrives in a cycle with no new event. If neither happens, the channel stays where it is. A request goes out when the channel's enable bit is set and either its flag is pending or, in low-level mode, its synchronized pin is low.

Software reaches four byte-wide registers through a simple strobe bus. Reads are combinational.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, all four registers read 0x00 and no request is asserted.
- R2: Register map. Address 0 holds the pin-1 sense in bits 3:2 and the pin-0 sense in bits 1:0. Address 1 holds the pin-2 polarity in bit 6. Address 2 holds the enables: bit 7 for pin 1, bit 6 for pin 0, bit 5 for pin 2. Address 3 holds the flags at those same bit positions. All other bits read 0, and read data is 0x00 while the read strobe is low.
- R3: In sense mode 00 (low level), with the enable set, a request is asserted while the synchronized pin is low. It follows the pin with two clock edges of delay, and no flag is latched.
- R4: In sense mode 01 (any change), both a rise and a fall of the pin set the flag.
- R5: In sense mode 10, only a falling edge sets the flag. In sense mode 11, only a rising edge sets the flag.
- R6: For pin 2, a polarity bit of 0 makes falling edges set the flag, and a polarity bit of 1 makes rising edges set it.
- R7: A pin change made between clock edges shows up in the flag register after the third rising clock edge, and not before.
- R8: A flag is latched whether or not its enable bit is set. A request is asserted only when both the flag and the enable are set.
- R9: Asserting a channel's acknowledge for one cycle clears that channel's flag.
- R10: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R11: When a new event and a clear (acknowledge or write-1) fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 3 | External interrupt pins, index = pin number |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| irq_ack | input | 3 | Per-source acknowledge from the interrupt controller |
| irq_req | output | 3 | Per-source interrupt request |
| reg_rdata | output | 8 | Read data |

## Verification
Two functions can land on the same clock edge: a flag being set by a new pin event, and that same flag being cleared. The bench provokes this by changing a pin and counting edges, so that the acknowledge, or the write-1 to the flag register, is held exactly across the edge where the synchronized event is first seen. The flag is then read back, and it must read as set. The same edge counting pins down the three-edge latency: the bench reads the flag just before the third edge and just after it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic prev
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   level,
    input  logic   prev,
    input  sense_e mode,
    input  logic   enable,
    input  logic   clr,
    output logic   flag,
    output logic   req
);
    flag_state_e state, state_nx;
    logic        hit;

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            SENSE_LOW:  hit = 1'b0;
            SENSE_ANY:  hit = level ^ prev;
            SENSE_FALL: hit = prev & ~level;
            SENSE_RISE: hit = ~prev & level;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_IDLE:    if (hit) state_nx = FLAG_PENDING;
            FLAG_PENDING: if (clr && !hit) state_nx = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FLAG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        flag = (state == FLAG_PENDING);
        if (mode == SENSE_LOW) req = enable & ~level;
        else                   req = enable & flag;
    end

    assert_flag_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> state == FLAG_PENDING);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr) |=> flag);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FLAG_PENDING && clr && !hit) |=> state == FLAG_IDLE);

    assert_level_noflag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LOW && state == FLAG_IDLE) |=> state == FLAG_IDLE);

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 3,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [NUM_PINS-1:0] irq_ack,
    output logic [NUM_PINS-1:0] irq_req,
    output logic [DATA_W-1:0]   reg_rdata
);
    localparam logic [ADDR_W-1:0] ADDR_SENSE_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_SENSE_B = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ENABLE  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_FLAG    = ADDR_W'(3);
    localparam int EDGE2_IDX = 2;
    localparam int POL_BIT   = 6;
    localparam int SENSE_A_W = 2 * EDGE2_IDX;
    localparam int CTL_BIT [NUM_PINS] = '{6, 7, 5};

    logic [SENSE_A_W-1:0] sense_a;
    logic                 pol2;
    logic [NUM_PINS-1:0]  enable;
    logic [NUM_PINS-1:0]  flag;
    logic [NUM_PINS-1:0]  clr;
    logic                 wr_flag;
    logic                 unused_wbits;

    assign wr_flag      = reg_wr && (reg_addr == ADDR_FLAG);
    assign unused_wbits = reg_wdata[4];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_a <= '0;
            pol2    <= 1'b0;
            enable  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_SENSE_A) sense_a <= reg_wdata[SENSE_A_W-1:0];
            if (reg_addr == ADDR_SENSE_B) pol2    <= reg_wdata[POL_BIT];
            if (reg_addr == ADDR_ENABLE) begin
                for (int i = 0; i < NUM_PINS; i++) enable[i] <= reg_wdata[CTL_BIT[i]];
            end
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chan
        logic   level, prev;
        sense_e mode;

        ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_i[g]),
            .level (level),
            .prev  (prev)
        );

        if (g == EDGE2_IDX) begin : g_edge_only
            assign mode = sense_e'({1'b1, pol2});
        end else begin : g_four_mode
            assign mode = sense_e'(sense_a[2*g +: 2]);
        end

        assign clr[g] = irq_ack[g] | (wr_flag & reg_wdata[CTL_BIT[g]]);

        ext_irq_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (level),
            .prev   (prev),
            .mode   (mode),
            .enable (enable[g]),
            .clr    (clr[g]),
            .flag   (flag[g]),
            .req    (irq_req[g])
        );

        assert_req_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[g] |-> enable[g]);
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                ADDR_SENSE_A: reg_rdata[SENSE_A_W-1:0] = sense_a;
                ADDR_SENSE_B: reg_rdata[POL_BIT]       = pol2;
                ADDR_ENABLE:  for (int i = 0; i < NUM_PINS; i++) reg_rdata[CTL_BIT[i]] = enable[i];
                ADDR_FLAG:    for (int i = 0; i < NUM_PINS; i++) reg_rdata[CTL_BIT[i]] = flag[i];
                default:      reg_rdata = '0;
            endcase
        end
    end

    assert_rdata_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> irq_req == '0);

endmodule

// File: tb/ext_irq_unit_test.sv
module ext_irq_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_i = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [2:0] irq_ack = '0;
    logic [2:0] irq_req;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit probe = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        bit         is_req;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_ack(irq_ack),
        .irq_req(irq_req), .reg_rdata(reg_rdata)
    );

    // monitor: pops one expected item per probed cycle
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (probe) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty actual=%h expected=item", reg_rdata);
            end else begin
                item_t it;
                logic [7:0] act;
                it  = sb.pop_front();
                act = it.is_req ? {5'b0, irq_req} : reg_rdata;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.is_req = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        reg_rd = 1'b1; reg_addr = a; probe = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; probe = 1'b0;
    endtask

    task automatic expect_req(input logic [2:0] e, input string tag);
        item_t it;
        it.is_req = 1'b1; it.exp = {5'b0, e}; it.tag = tag;
        sb.push_back(it);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack(input logic [2:0] m);
        irq_ack = m;
        @(negedge clk);
        irq_ack = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        expect_rd(2'd0, 8'h00, "R1 sense A after reset");
        expect_rd(2'd1, 8'h00, "R1 sense B after reset");
        expect_rd(2'd2, 8'h00, "R1 enable after reset");
        expect_rd(2'd3, 8'h00, "R1 flags after reset");
        expect_req(3'b000, "R1 no request after reset");

        // R2 register map and unused bits
        do_write(2'd0, 8'hFF);
        expect_rd(2'd0, 8'h0F, "R2 sense A bits");
        do_write(2'd1, 8'hFF);
        expect_rd(2'd1, 8'h40, "R2 polarity bit");
        do_write(2'd2, 8'hFF);
        expect_rd(2'd2, 8'hE0, "R2 enable bits");
        expect_req(3'b000, "R8 enabled but no flag");
        do_write(2'd2, 8'h00);
        do_write(2'd0, 8'h00);
        do_write(2'd1, 8'h00);

        // R3 low level mode on pin 0
        do_write(2'd2, 8'h40);
        expect_req(3'b001, "R3 low pin requests");
        pin_i[0] = 1'b1;
        idle(2);
        expect_req(3'b000, "R3 high pin no request");
        expect_rd(2'd3, 8'h00, "R3 no flag latched");
        pin_i[0] = 1'b0;
        idle(2);
        expect_req(3'b001, "R3 low again requests");
        do_write(2'd2, 8'h00);

        // R4 any change, R8 enable gating, R9 ack, R10 write clear
        do_write(2'd0, 8'h01);
        pin_i[0] = 1'b1;
        idle(3);
        expect_rd(2'd3, 8'h40, "R4 rise sets flag");
        expect_req(3'b000, "R8 flag without enable");
        do_write(2'd2, 8'h40);
        expect_req(3'b001, "R8 flag and enable");
        pulse_ack(3'b001);
        expect_rd(2'd3, 8'h00, "R9 ack clears flag");
        expect_req(3'b000, "R9 request drops");
        pin_i[0] = 1'b0;
        idle(3);
        expect_rd(2'd3, 8'h40, "R4 fall sets flag");
        do_write(2'd3, 8'h00);
        expect_rd(2'd3, 8'h40, "R10 write 0 keeps flag");
        do_write(2'd3, 8'h40);
        expect_rd(2'd3, 8'h00, "R10 write 1 clears flag");
        do_write(2'd2, 8'h00);

        // R5 pin1 falling, pin0 rising
        do_write(2'd0, 8'h0B);
        pin_i[1] = 1'b1;
        idle(3);
        expect_rd(2'd3, 8'h00, "R5 rise ignored in falling mode");
        pin_i[0] = 1'b1;
        idle(3);
        expect_rd(2'd3, 8'h40, "R5 rise sets in rising mode");
        pin_i[1] = 1'b0;
        idle(3);
        expect_rd(2'd3, 8'hC0, "R5 fall sets in falling mode");
        do_write(2'd3, 8'hC0);
        pin_i[0] = 1'b0;
        idle(3);
        expect_rd(2'd3, 8'h00, "R5 fall ignored in rising mode");

        // R6 pin 2 polarity
        pin_i[2] = 1'b1;
        idle(3);
        expect_rd(2'd3, 8'h00, "R6 rise ignored with polarity 0");
        pin_i[2] = 1'b0;
        idle(3);
        expect_rd(2'd3, 8'h20, "R6 fall sets with polarity 0");
        do_write(2'd3, 8'h20);
        do_write(2'd1, 8'h40);
        pin_i[2] = 1'b1;
        idle(3);
        expect_rd(2'd3, 8'h20, "R6 rise sets with polarity 1");
        do_write(2'd3, 8'h20);
        pin_i[2] = 1'b0;
        idle(3);
        expect_rd(2'd3, 8'h00, "R6 fall ignored with polarity 1");

        // R7 latency: pin 0 rising mode
        do_write(2'd0, 8'h03);
        pin_i[0] = 1'b1;
        idle(2);
        expect_rd(2'd3, 8'h00, "R7 not before third edge");
        expect_rd(2'd3, 8'h40, "R7 after third edge");
        do_write(2'd3, 8'h40);

        // R11 event and acknowledge on the same edge
        pin_i[0] = 1'b0;
        idle(3);
        pin_i[0] = 1'b1;
        idle(2);
        irq_ack = 3'b001;
        @(negedge clk);
        irq_ack = '0;
        expect_rd(2'd3, 8'h40, "R11 set beats ack");

        // R11 event and write-1 clear on the same edge (any-change mode)
        do_write(2'd0, 8'h01);
        do_write(2'd3, 8'h40);
        expect_rd(2'd3, 8'h00, "R10 cleared before race");
        pin_i[0] = 1'b0;
        idle(2);
        do_write(2'd3, 8'h40);
        expect_rd(2'd3, 8'h40, "R11 set beats write clear");

        idle(2);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule